// File: doc/BRIEF.md
# Master/Slave Serial Peripheral Port with Fault Detection

This block is a byte-wide serial peripheral port that can run as bus master or as a selected slave. Each transfer exchanges eight bits in both directions at once, most significant bit first: one bit goes out on the outgoing data line while one bit comes in on the incoming line, and the serial clock paces both. Software sets the clock idle level and the sampling phase. Together these two settings give the four usual clocking protocols.

Software works the port through four byte registers on a simple synchronous bus. A write is one `wr_i` cycle. A read is combinational on `rdata_o`, and its side effects take place at the clock edge while `rd_i` is high. As master, the port divides the system clock by 4, 8, 16 or 32 to make the serial clock, and it drives eight active-low select lines from a register. As slave, it brings the external clock, data and select into the system clock domain through two-flop synchronizers. It follows the external clock only while its select input is low.

If another device pulls the select input low while this port is master, the port records a mode fault. It drops its enable and master bits, which releases every output driver, and it waits for software to enable it again.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register (address 0) and status register (address 1) read 0. `ss_no` is all ones, and `sck_oe_o`, `mosi_oe_o` and `miso_oe_o` are low.
- R2: Control bits [5:4] select the master clock rate. A value r gives a serial clock half period of 2^(r+1) system clocks, which is clk/4, clk/8, clk/16 or clk/32.
- R3: Control bit 2 sets the idle level of `sck_o`. Control bit 3 set to 0 samples on the leading edge and shifts on the trailing edge; set to 1, it shifts on the leading edge and samples on the trailing edge. Data moves MSB first in both directions at once.
- R4: In master mode, a write to the data register (address 2) while idle starts a transfer. When the transfer ends, status bit 0 (complete) is set and a read of the data register returns the received byte.
- R5: A data write while a transfer is in progress sets status bit 1 (collision). The write is dropped, and the byte in flight is unchanged.
- R6: Status flags clear only when a status read that saw a flag set is followed by a data register access. A status read by itself leaves the flags set.
- R7: If `ss_ni` is low while control bit 0 (enable) and bit 1 (master) are set, status bit 2 (fault) is set. Enable and master clear, all output enables go low, and the port stays off until control is rewritten.
- R8: In master mode, `ss_no` follows the select register (address 3). In any other mode it is all ones.
- R9: In slave mode with `ss_ni` low, the port exchanges a byte on the external clock, drives `miso_oe_o` and sets the complete flag after the eighth bit. With `ss_ni` high, it ignores `sck_i` and its data output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe_o | output | 1 | Serial clock driver enable |
| mosi_i | input | 1 | Master-to-slave data in (slave mode) |
| mosi_o | output | 1 | Master-to-slave data out (master mode) |
| mosi_oe_o | output | 1 | Master-to-slave driver enable |
| miso_i | input | 1 | Slave-to-master data in (master mode) |
| miso_o | output | 1 | Slave-to-master data out (slave mode) |
| miso_oe_o | output | 1 | Slave-to-master driver enable |
| ss_ni | input | 1 | Slave select input, active low |
| ss_no | output | 8 | Slave select outputs, active low |

## Verification
The bench runs all four clock protocols with bytes whose first and last bits differ. A design that samples and shifts on swapped edges, or that drops the first bit when shifting on the leading edge, then delivers a rotated byte to the bench's slave model or to the data register. It measures the serial clock half period at every rate, so a divider that is off by one or wrong by a factor of two shows up. It writes data in the middle of a transfer, which catches a design that reloads the shifter or fails to raise the collision flag. It also checks that a status read alone does not clear flags. It pulls the select input low during master operation and checks that the drivers and mode bits drop and that a later re-enable works. In slave mode it toggles the clock while the port is deselected, which exposes a design that counts those stray bits.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned RATE_W = 2;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_SSEL = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;  // [5:4]
    logic              cpha;  // [3]
    logic              cpol;  // [2]
    logic              mstr;  // [1]
    logic              en;    // [0]
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              edge_o
);
  localparam int unsigned CNT_W = (1 << RATE_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  assign half_m1 = (CNT_W'(2) << rate_i) - CNT_W'(1);
  assign edge_o  = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (edge_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + CNT_W'(1);
  end

  // shortest half period is two clocks
  p_edge_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         clear_i,
  input  logic         sample_i,
  input  logic         drive_i,
  input  logic         cpha_i,
  input  logic         in_i,
  output logic         out_o,
  output logic [W-1:0] rx_o,
  output logic         full_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  txd_q, rxd_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;

  assign out_o  = txd_q[W-1];
  assign rx_o   = {rxd_q[W-2:0], in_i};
  assign full_o = sample_i && !load_i && !clear_i && (cnt_q == CW'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q   <= '0;
      rxd_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (load_i) begin
      txd_q   <= load_data_i;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (clear_i) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      if (sample_i) begin
        rxd_q <= rx_o;
        cnt_q <= full_o ? '0 : cnt_q + CW'(1);
      end
      if (drive_i) begin
        // leading-edge shifting presents the MSB on the first edge, no shift
        if (!(cpha_i && first_q)) txd_q <= {txd_q[W-2:0], 1'b0};
        first_q <= 1'b0;
      end
      if (full_o) first_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned SS_N = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            sck_oe_o,
  input  logic            mosi_i,
  output logic            mosi_o,
  output logic            mosi_oe_o,
  input  logic            miso_i,
  output logic            miso_o,
  output logic            miso_oe_o,
  input  logic            ss_ni,
  output logic [SS_N-1:0] ss_no
);
  localparam int unsigned EW     = $clog2(2 * DW);
  localparam logic [EW-1:0] LAST = EW'(2 * DW - 1);

  ctrl_t           ctrl_q;
  logic [SS_N-1:0] ssel_q;
  logic [DW-1:0]   rx_buf_q;
  logic            done_q, wcol_q, modf_q, armed_q;
  logic            m_run_q, phase_q;
  logic [EW-1:0]   ecnt_q;

  // {sck, mosi, ss} two-flop synchronizer
  logic [2:0] sync1_q, sync2_q;
  logic       sck_d_q;
  logic       sck_s, mosi_s, ss_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 3'b001;
      sync2_q <= 3'b001;
      sck_d_q <= 1'b0;
    end else begin
      sync1_q <= {sck_i, mosi_i, ss_ni};
      sync2_q <= sync1_q;
      sck_d_q <= sync2_q[2];
    end
  end
  assign {sck_s, mosi_s, ss_s} = sync2_q;

  logic m_mode, s_mode, s_sel, fault;
  assign m_mode = ctrl_q.en && ctrl_q.mstr;
  assign s_mode = ctrl_q.en && !ctrl_q.mstr;
  assign s_sel  = s_mode && !ss_s;
  assign fault  = m_mode && !ss_s;

  logic data_wr, data_acc, stat_rd, busy, start;
  assign data_wr  = wr_i && (addr_i == A_DATA);
  assign data_acc = (wr_i || rd_i) && (addr_i == A_DATA);
  assign stat_rd  = rd_i && (addr_i == A_STAT);
  assign busy     = m_run_q || s_sel;
  assign start    = data_wr && m_mode && !m_run_q;

  // master clock
  logic edge_p, m_sample, m_drive, m_end;
  spi_sck_gen #(.RATE_W(RATE_W)) u_sck_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (m_run_q),
    .rate_i (ctrl_q.rate),
    .edge_o (edge_p)
  );
  assign m_sample = edge_p && (phase_q == ctrl_q.cpha);
  assign m_drive  = edge_p && (phase_q != ctrl_q.cpha);
  assign m_end    = edge_p && (ecnt_q == LAST);

  // slave clock edges
  logic s_edge, s_lead, s_sample, s_drive;
  assign s_edge   = s_sel && (sck_s != sck_d_q);
  assign s_lead   = sck_d_q == ctrl_q.cpol;
  assign s_sample = s_edge && (s_lead == !ctrl_q.cpha);
  assign s_drive  = s_edge && !(s_lead == !ctrl_q.cpha);

  logic          c_out, c_full;
  logic [DW-1:0] c_rx;
  spi_shift_core #(.W(DW)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (data_wr && !busy),
    .load_data_i (wdata_i),
    .clear_i     (!ctrl_q.en || (s_mode && ss_s) || fault),
    .sample_i    (m_mode ? m_sample : s_sample),
    .drive_i     (m_mode ? m_drive : s_drive),
    .cpha_i      (ctrl_q.cpha),
    .in_i        (m_mode ? miso_i : mosi_s),
    .out_o       (c_out),
    .rx_o        (c_rx),
    .full_o      (c_full)
  );

  logic set_done, set_wcol, clr;
  assign set_done = (m_mode && m_end) || (s_mode && c_full);
  assign set_wcol = data_wr && busy;
  assign clr      = armed_q && data_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ssel_q   <= '1;
      rx_buf_q <= '0;
      done_q   <= 1'b0;
      wcol_q   <= 1'b0;
      modf_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_i && addr_i == A_SSEL) ssel_q <= wdata_i[SS_N-1:0];
      if (fault) begin
        ctrl_q.en   <= 1'b0;
        ctrl_q.mstr <= 1'b0;
      end
      if (c_full) rx_buf_q <= c_rx;
      done_q  <= set_done || (done_q && !clr);
      wcol_q  <= set_wcol || (wcol_q && !clr);
      modf_q  <= fault    || (modf_q && !clr);
      if (clr)                                     armed_q <= 1'b0;
      else if (stat_rd && (done_q || wcol_q || modf_q)) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run_q <= 1'b0;
      phase_q <= 1'b0;
      ecnt_q  <= '0;
    end else if (fault || !m_mode) begin
      m_run_q <= 1'b0;
      phase_q <= 1'b0;
      ecnt_q  <= '0;
    end else if (start) begin
      m_run_q <= 1'b1;
      phase_q <= 1'b0;
      ecnt_q  <= '0;
    end else if (edge_p) begin
      phase_q <= ~phase_q;
      ecnt_q  <= ecnt_q + EW'(1);
      if (m_end) m_run_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = DW'(ctrl_q);
      A_STAT:  rdata_o = DW'({modf_q, wcol_q, done_q});
      A_DATA:  rdata_o = rx_buf_q;
      default: rdata_o = DW'(ssel_q);
    endcase
  end

  assign sck_o     = ctrl_q.cpol ^ phase_q;
  assign sck_oe_o  = m_mode;
  assign mosi_o    = c_out;
  assign mosi_oe_o = m_mode;
  assign miso_o    = c_out;
  assign miso_oe_o = s_sel;
  assign ss_no     = m_mode ? ssel_q : '1;

  p_modf_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modf_q) |-> (!ctrl_q.en && !ctrl_q.mstr && !sck_oe_o && !mosi_oe_o));
  p_wcol_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && m_run_q) |=> wcol_q);
  p_sck_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_run_q |-> (sck_o == ctrl_q.cpol));
  p_done_seen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_done |=> done_q);
  p_ss_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_mode && ss_s) |-> !c_full);
endmodule

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_ni = 1'b1;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic [7:0] ss_no;

  always #2.5 clk = ~clk;

  spi_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe),
    .ss_ni(ss_ni), .ss_no(ss_no)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rx[$];

  always @(negedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // slave model / monitor for master mode
  logic       m_on = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, m_first = 1'b1;
  logic [7:0] m_tx = '0, m_rx = '0;
  int         m_cnt = 0, nedge = 0, t0 = 0, t1 = 0;

  always @(sck_o) begin
    if (m_on) begin
      if (nedge == 0) t0 = cyc;
      if (nedge == 1) t1 = cyc;
      nedge++;
      if ((sck_o != m_cpol) == !m_cpha) begin
        m_rx = {m_rx[6:0], mosi_o};
        m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0;
          if (exp_mosi.size() == 0) chk(1'b0, "R3 queue", 0, 1);
          else begin
            logic [7:0] e;
            e = exp_mosi.pop_front();
            chk(m_rx == e, "R3 mosi byte", m_rx, e);
          end
        end
      end else begin
        if (m_cpha && m_first) m_first = 1'b0;
        else m_tx = {m_tx[6:0], 1'b0};
        miso_i = m_tx[7];
      end
    end
  end

  task automatic master_xfer(input logic [1:0] rate, input logic cpol, input logic cpha,
                             input logic [7:0] dtx, input logic [7:0] stx, input bit collide);
    logic [7:0] st, d;
    int n;
    bus_wr(2'd0, {2'b00, rate, cpha, cpol, 2'b11});
    chk(sck_o == cpol, "R3 idle level", sck_o, cpol);
    m_cpol = cpol; m_cpha = cpha; m_tx = stx; miso_i = stx[7];
    m_first = 1'b1; m_cnt = 0; nedge = 0; m_on = 1'b1;
    exp_mosi.push_back(dtx);
    exp_rx.push_back(stx);
    bus_wr(2'd2, dtx);
    if (collide) begin
      repeat (10) @(negedge clk);
      bus_wr(2'd2, ~dtx);
    end
    n = 0;
    do begin bus_rd(2'd1, st); n++; end while (!st[0] && n < 500);
    chk(st[0] == 1'b1, "R4 complete flag", st, 1);
    chk(st[1] == collide, "R5 collision flag", st[1], collide);
    chk((t1 - t0) == (2 << rate), "R2 half period", t1 - t0, 2 << rate);
    if (collide) begin
      bus_rd(2'd1, st);
      chk(st[1:0] == 2'b11, "R6 status read alone keeps flags", st, 3);
    end
    bus_rd(2'd2, d);
    chk(d == exp_rx[0], "R4 received byte", d, exp_rx[0]);
    void'(exp_rx.pop_front());
    bus_rd(2'd1, st);
    chk(st == 8'h00, "R6 flags cleared", st, 0);
    m_on = 1'b0;
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha,
                            input logic [7:0] dtx, input logic [7:0] ttx);
    logic [7:0] got, st, d;
    got = '0;
    sck_i = cpol; ss_ni = 1'b1;
    bus_wr(2'd0, {4'b0000, cpha, cpol, 2'b01});
    repeat (4) @(negedge clk);
    bus_wr(2'd2, dtx);
    chk(ss_no == 8'hFF, "R8 slave mode selects idle", ss_no, 8'hFF);
    chk(miso_oe == 1'b0, "R9 output off while deselected", miso_oe, 0);
    exp_rx.push_back(ttx);
    mosi_i = ttx[7];
    ss_ni = 1'b0;
    repeat (8) @(negedge clk);
    chk(miso_oe == 1'b1, "R9 output on while selected", miso_oe, 1);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = ttx[7-i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = ~cpol;
        repeat (8) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol; mosi_i = ttx[7-i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(got == dtx, "R9 slave output byte", got, dtx);
    bus_rd(2'd1, st);
    chk(st[0] == 1'b1, "R9 slave complete", st, 1);
    bus_rd(2'd2, d);
    chk(d == exp_rx[0], "R9 slave received byte", d, exp_rx[0]);
    void'(exp_rx.pop_front());
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_rd(2'd0, v); chk(v == 8'h00, "R1 control", v, 0);
    bus_rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);
    chk(ss_no == 8'hFF, "R1 selects", ss_no, 8'hFF);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R1 drivers", {sck_oe, mosi_oe, miso_oe}, 0);

    // R3/R4 all four protocols at top rate
    master_xfer(2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C, 0);
    master_xfer(2'd0, 1'b0, 1'b1, 8'h81, 8'h7E, 0);
    master_xfer(2'd0, 1'b1, 1'b0, 8'h1F, 8'hC2, 0);
    master_xfer(2'd0, 1'b1, 1'b1, 8'hE4, 8'h09, 0);
    // R2 remaining rates
    master_xfer(2'd1, 1'b0, 1'b0, 8'h5A, 8'h96, 0);
    master_xfer(2'd2, 1'b1, 1'b1, 8'h01, 8'h80, 0);
    master_xfer(2'd3, 1'b0, 1'b1, 8'hFE, 8'h6D, 0);
    // R5/R6 collision during transfer
    master_xfer(2'd2, 1'b0, 1'b0, 8'hC3, 8'h55, 1);

    // R8 select register
    bus_wr(2'd3, 8'hFB);
    chk(ss_no == 8'hFB, "R8 select outputs", ss_no, 8'hFB);
    bus_rd(2'd3, v); chk(v == 8'hFB, "R8 select readback", v, 8'hFB);

    // R7 mode fault
    ss_ni = 1'b0;
    repeat (5) @(negedge clk);
    bus_rd(2'd1, v); chk(v[2] == 1'b1, "R7 fault flag", v, 4);
    bus_rd(2'd0, v); chk(v[1:0] == 2'b00, "R7 enable and master cleared", v[1:0], 0);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R7 drivers off", {sck_oe, mosi_oe, miso_oe}, 0);
    chk(ss_no == 8'hFF, "R7 selects released", ss_no, 8'hFF);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); chk(v == 8'h00, "R6 fault cleared", v, 0);
    master_xfer(2'd0, 1'b0, 1'b0, 8'h66, 8'h99, 0);

    // R9 slave ignores clock while deselected
    bus_wr(2'd0, 8'h01);
    ss_ni = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sck_i = ~sck_i; mosi_i = i[0];
      repeat (6) @(negedge clk);
    end
    bus_rd(2'd1, v); chk(v == 8'h00, "R9 deselected clock ignored", v, 0);

    slave_xfer(1'b0, 1'b0, 8'hB7, 8'h4E);
    slave_xfer(1'b1, 1'b1, 8'h2D, 8'hF0);
    slave_xfer(1'b0, 1'b1, 8'h93, 8'h18);

    chk(exp_mosi.size() == 0, "R3 all bytes seen", exp_mosi.size(), 0);
    finish_run();
  end
endmodule